// File: doc/BRIEF.md
# Reduced-pin Ethernet receive to nibble adapter

The block sits between a reduced-pin Ethernet PHY receive port and a MAC receive path that consumes four-bit nibbles. On every rising edge of the 50 MHz reference clock it samples a two-bit receive symbol, the combined carrier-sense/data-valid input and the PHY receive-error input. It pairs successive symbols into nibbles and emits each nibble with a one-cycle valid strobe. When the combined carrier/valid input falls, it closes the frame with a one-cycle end pulse and a matching error flag.

A frame opens when carrier/valid is sampled high. Symbols of value 00 at the start of a frame are idle and are skipped. The first non-zero symbol starts the nibble alignment. The error flag reports a PHY receive error seen at any point while carrier/valid was high. It also reports a frame that stopped with half a nibble pending. That half nibble is dropped. Preamble removal, CRC checking and 10 Mb/s decimation are left to the MAC.

Top module: `rmii_nib_rx`

## Requirements
- R1: During and after reset, until carrier/valid is first sampled high, `nib_vld_o`, `frame_end_o` and `frame_err_o` are 0.
- R2: Symbols are taken only at edges where `crs_dv_i` is 1. After carrier/valid rises, 00 symbols are skipped until the first non-zero symbol, which is taken as the first symbol of a nibble. From then on, every symbol is taken, zeros included, until carrier/valid falls.
- R3: The first taken symbol of a pair goes to `nib_o[1:0]` and the second to `nib_o[3:2]`. `nib_vld_o` is 1 for one cycle, in the cycle after the edge that sampled the second symbol, with `nib_o` holding the nibble.
- R4: `nib_vld_o` is never 1 in two consecutive cycles. It is 0 in any cycle whose preceding edge sampled `crs_dv_i` low.
- R5: The first edge that samples `crs_dv_i` low after an edge that sampled it high makes `frame_end_o` 1 for exactly the next cycle.
- R6: If `rx_er_i` is 1 at any edge where `crs_dv_i` is 1 within a frame, `frame_err_o` is 1 together with that frame's end pulse. `rx_er_i` at edges where `crs_dv_i` is 0 has no effect.
- R7: If carrier/valid falls after an odd number of taken symbols, the leftover symbol produces no nibble and `frame_err_o` is 1 with the end pulse.
- R8: `frame_err_o` is 1 only in a cycle where `frame_end_o` is 1. The error state is cleared at each frame end, so a clean frame that follows a bad frame ends with `frame_err_o` at 0.
- R9: A frame made only of 00 symbols ends with an end pulse, no nibble and `frame_err_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | DW (2) | Receive symbol from the PHY |
| crs_dv_i | input | 1 | Combined carrier sense / receive data valid |
| rx_er_i | input | 1 | PHY receive error |
| nib_o | output | SYM_W (4) | Assembled nibble |
| nib_vld_o | output | 1 | Nibble valid strobe |
| frame_end_o | output | 1 | One-cycle frame end pulse |
| frame_err_o | output | 1 | Frame error flag, valid with the end pulse |

## Verification
The bench builds the block with its default widths: two-bit symbols and four-bit nibbles. At these widths every nibble is exactly one symbol pair. This puts the odd-count truncation, the leading-zero hunt and the alignment of a first symbol of 10 or 11 within reach of short directed frames. A behavioural model is compared with all outputs on every clock. Directed frames cover a receive error inside a frame and one outside it, and frames separated by a single idle cycle. A pseudo-random stream then stresses the symbol pairing.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
  function automatic int unsigned syms_per_nib(int unsigned sym_w, int unsigned dw);
    return sym_w / dw;
  endfunction
endpackage

// File: rtl/rmii_carrier_edge.sv
module rmii_carrier_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic crs_dv_i,
  output logic stop_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= crs_dv_i;
  end

  // carrier just lost: previous edge high, this edge low
  assign stop_o = busy_q & ~crs_dv_i;

  p_stop_once_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !stop_o);
endmodule

// File: rtl/rmii_dibit_pack.sv
module rmii_dibit_pack #(
  parameter int unsigned DW    = 2,
  parameter int unsigned SYM_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DW-1:0]    rxd_i,
  input  logic             crs_dv_i,
  output logic [SYM_W-1:0] sym_o,
  output logic             sym_vld_o,
  output logic             partial_o
);
  import rmii_rx_pkg::*;
  localparam int unsigned DPS = syms_per_nib(SYM_W, DW);
  localparam int unsigned CW  = (DPS > 1) ? $clog2(DPS) : 1;

  logic [CW-1:0]    cnt_q;
  logic             locked_q;
  logic [SYM_W-1:0] sh_q;
  logic             take;
  logic             last;
  logic [SYM_W-1:0] sh_nxt;

  assign take   = crs_dv_i && (locked_q || (|rxd_i));
  assign last   = (cnt_q == CW'(DPS - 1));
  assign sh_nxt = {rxd_i, sh_q[SYM_W-1:DW]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      locked_q  <= 1'b0;
      sh_q      <= '0;
      sym_o     <= '0;
      sym_vld_o <= 1'b0;
    end else if (!crs_dv_i) begin
      cnt_q     <= '0;
      locked_q  <= 1'b0;
      sym_vld_o <= 1'b0;
    end else begin
      sym_vld_o <= take && last;
      if (take) begin
        locked_q <= 1'b1;
        sh_q     <= sh_nxt;
        if (last) begin
          cnt_q <= '0;
          sym_o <= sh_nxt;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign partial_o = (cnt_q != '0);

  p_vld_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o |=> !sym_vld_o);
  p_vld_needs_carrier_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !crs_dv_i |=> !sym_vld_o);
  p_lock_needs_carrier_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !crs_dv_i |=> !locked_q);
endmodule

// File: rtl/rmii_frame_status.sv
module rmii_frame_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic crs_dv_i,
  input  logic rx_er_i,
  input  logic stop_i,
  input  logic partial_i,
  output logic end_o,
  output logic err_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      end_o <= 1'b0;
      err_o <= 1'b0;
    end else begin
      end_o <= stop_i;
      err_o <= stop_i & (err_q | partial_i);
      if (stop_i)                  err_q <= 1'b0;
      else if (crs_dv_i & rx_er_i) err_q <= 1'b1;
    end
  end

  p_partial_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && partial_i) |=> err_o);
  p_err_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !err_q);
endmodule

// File: rtl/rmii_nib_rx.sv
module rmii_nib_rx #(
  parameter int unsigned DW    = 2,
  parameter int unsigned SYM_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DW-1:0]    rxd_i,
  input  logic             crs_dv_i,
  input  logic             rx_er_i,
  output logic [SYM_W-1:0] nib_o,
  output logic             nib_vld_o,
  output logic             frame_end_o,
  output logic             frame_err_o
);
  logic stop;
  logic partial;

  rmii_carrier_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .crs_dv_i (crs_dv_i),
    .stop_o   (stop)
  );

  rmii_dibit_pack #(.DW(DW), .SYM_W(SYM_W)) u_pack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rxd_i     (rxd_i),
    .crs_dv_i  (crs_dv_i),
    .sym_o     (nib_o),
    .sym_vld_o (nib_vld_o),
    .partial_o (partial)
  );

  rmii_frame_status u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .crs_dv_i  (crs_dv_i),
    .rx_er_i   (rx_er_i),
    .stop_i    (stop),
    .partial_i (partial),
    .end_o     (frame_end_o),
    .err_o     (frame_err_o)
  );

  p_err_with_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> frame_end_o);
  p_end_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> !frame_end_o);
  p_end_after_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crs_dv_i ##1 !crs_dv_i) |=> frame_end_o);
  p_no_vld_at_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nib_vld_o && frame_end_o));
endmodule

// File: tb/sim_rmii_nib_rx.sv
module sim_rmii_nib_rx;
  localparam int CLK_PERIOD = 20;
  localparam int MAX_CYC    = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rxd = 2'b00;
  logic       crs = 1'b0;
  logic       er  = 1'b0;
  logic [3:0] nib;
  logic       vld, fend, ferr;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  string scen = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  rmii_nib_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .crs_dv_i(crs), .rx_er_i(er),
    .nib_o(nib), .nib_vld_o(vld), .frame_end_o(fend), .frame_err_o(ferr)
  );

  // behavioural reference
  bit m_busy, m_lock, m_err;
  int m_cnt;
  logic [1:0] m_lo;
  logic [3:0] e_nib;
  bit e_vld, e_end, e_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_lock = 0; m_err = 0; m_cnt = 0;
      e_vld = 0; e_end = 0; e_err = 0; e_nib = '0; m_lo = '0;
    end else begin
      e_vld = 0; e_end = 0; e_err = 0;
      if (crs) begin
        if (m_lock || rxd != 2'b00) begin
          m_lock = 1;
          if (m_cnt == 0) begin m_lo = rxd; m_cnt = 1; end
          else begin e_nib = {rxd, m_lo}; e_vld = 1; m_cnt = 0; end
        end
        if (er) m_err = 1;
      end else begin
        if (m_busy) begin e_end = 1; e_err = m_err || (m_cnt != 0); end
        m_lock = 0; m_cnt = 0; m_err = 0;
      end
      m_busy = crs;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) cyc %0d act=%0h exp=%0h", req, scen, cyc, act, exp);
    end
  endtask

  // monitor: per-cycle compare plus frame capture
  logic [3:0] cap[$];
  int ends = 0;
  bit last_err = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      chk(vld == e_vld, "R4", vld, e_vld);
      if (e_vld) chk(nib == e_nib, "R3", nib, e_nib);
      chk(fend == e_end, "R5", fend, e_end);
      chk(ferr == e_err, "R6", ferr, e_err);
      if (vld) cap.push_back(nib);
      if (fend) begin ends++; last_err = ferr; end
    end
  end

  task automatic sym(input logic [1:0] d, input bit c, input bit e = 0);
    @(negedge clk); rxd = d; crs = c; er = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) sym(2'b00, 0);
  endtask

  task automatic frame_check(input string req, input logic [3:0] exp[$], input bit exp_err);
    idle(2);
    chk(cap.size() == exp.size(), req, cap.size(), exp.size());
    for (int i = 0; i < exp.size() && i < cap.size(); i++)
      chk(cap[i] == exp[i], req, cap[i], exp[i]);
    chk(ends == 1, req, ends, 1);
    chk(last_err == exp_err, req, last_err, exp_err);
    cap.delete(); ends = 0; last_err = 0;
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired act=%0d exp=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] exp[$];
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    scen = "R1";
    chk(vld == 0 && fend == 0 && ferr == 0, "R1 in reset", {vld, fend, ferr}, 0);
    rst_n = 1;
    idle(3);
    chk(vld == 0 && fend == 0 && ferr == 0, "R1 after reset", {vld, fend, ferr}, 0);

    // R2/R3: leading zeros skipped, low symbol first
    scen = "R2_R3";
    sym(2'b00, 1); sym(2'b00, 1); sym(2'b01, 1); sym(2'b11, 1);
    sym(2'b10, 1); sym(2'b00, 1); sym(2'b11, 1); sym(2'b01, 1);
    sym(2'b00, 0);
    exp = '{4'hD, 4'h2, 4'h7};
    frame_check("R2 R3", exp, 0);

    // R2: first non-zero 10 starts alignment
    scen = "R2_align";
    sym(2'b00, 1); sym(2'b10, 1); sym(2'b01, 1); sym(2'b00, 1); sym(2'b00, 1);
    sym(2'b00, 0);
    exp = '{4'h6, 4'h0};
    frame_check("R2 align", exp, 0);

    // R6: receive error inside a frame
    scen = "R6_in";
    sym(2'b01, 1); sym(2'b01, 1, 1); sym(2'b11, 1); sym(2'b11, 1);
    sym(2'b00, 0);
    exp = '{4'h5, 4'hF};
    frame_check("R6 in frame", exp, 1);

    // R6/R8: error outside the frame ignored, error state cleared
    scen = "R6_out_R8";
    sym(2'b00, 0, 1); sym(2'b00, 0, 1);
    sym(2'b11, 1); sym(2'b10, 1); sym(2'b00, 0, 1);
    exp = '{4'hB};
    frame_check("R8 clean after bad", exp, 0);

    // R7: odd symbol count
    scen = "R7";
    sym(2'b01, 1); sym(2'b00, 1); sym(2'b11, 1); sym(2'b00, 0);
    exp = '{4'h1};
    frame_check("R7 odd count", exp, 1);

    // R9: zeros only
    scen = "R9";
    sym(2'b00, 1); sym(2'b00, 1); sym(2'b00, 1); sym(2'b00, 0);
    exp = '{};
    frame_check("R9 zero frame", exp, 0);

    // R5: back-to-back frames with one idle cycle
    scen = "R5_b2b";
    sym(2'b01, 1); sym(2'b10, 1); sym(2'b00, 0);
    sym(2'b11, 1); sym(2'b01, 1); sym(2'b00, 0);
    idle(2);
    chk(ends == 2, "R5 two ends", ends, 2);
    chk(cap.size() == 2, "R5 two nibbles", cap.size(), 2);
    cap.delete(); ends = 0; last_err = 0;

    // pseudo-random stream, compared by the per-cycle model
    scen = "R3_rand";
    lfsr = 16'hACE1;
    for (int f = 0; f < 40; f++) begin
      int len;
      len = 4 + (lfsr[5:0]);
      for (int i = 0; i < len; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        sym(lfsr[1:0], 1, (lfsr[15:8] == 8'h3C));
      end
      idle(1 + lfsr[2]);
    end
    idle(3);
    cap.delete();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule